// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

A registered arithmetic slice for datapath chains. Two 18-bit inputs are summed or differenced in a pre-adder, and the result is multiplied by an 18-bit operand. That operand comes from a port, or from a small computed constant ROM when the build parameter selects it. The product is then combined with a 48-bit addend, a carry-in bit and a selectable third operand. The third operand is the cascade input, the slice's own result fed back, or zero, and it can be arithmetic-shifted right by 17 bits.

Inputs and controls are captured on one rising edge, and the result register loads on the next. An input set therefore appears at the result two cycles after it was driven. A copy of the result and a one-cycle-delayed copy of B leave the slice on cascade outputs, so that neighbouring slices can chain accumulations or share a B operand. All arithmetic is signed two's complement.

Top module: `pa_macc_slice`

## Requirements
- R1: While rst_ni is low, p_o, cdout_o, b2_o, bcout_o and ovfl_o are all zero.
- R2: Two rising edges after an input set is driven and held, p_o equals E' + C + CARRYIN + A×(B+D). All terms are sign-extended, and the result is truncated to 48 bits.
- R3: When pasub_i is 1, the pre-adder forms B−D in place of B+D.
- R4: When sub_i is 1, the product term enters the sum negated.
- R5: The operand select esel_i takes E from zero for 2'b00, from p_o for 2'b01 and from cdin_i for 2'b10. The code 2'b11 is reserved and gives zero.
- R6: When arsh_i is 1, the selected E is shifted right arithmetically by 17 bits, and its sign fills the vacated upper bits.
- R7: With esel_i = 2'b01 held, p_o grows by the remaining terms on every clock edge. When all of those terms are zero, p_o holds its value.
- R8: With USE_ROM = 1, the multiplier operand is ROM entry k, selected by rom_addr_i = k, and holds 4096·k − 30000. a_i has no effect in this mode.
- R9: ovfl_o is 1 in the same cycle as p_o exactly when the full-precision sum lies outside the signed 48-bit range. In that case p_o holds the wrapped low 48 bits.
- R10: cdout_o always equals p_o. b2_o and bcout_o equal b_i as captured on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Multiplier operand (port mode) |
| b_i | input | 18 | Pre-adder operand B |
| d_i | input | 18 | Pre-adder operand D |
| c_i | input | 48 | Addend C |
| cin_i | input | 1 | Carry-in added with C |
| cdin_i | input | 48 | Cascade input for operand E |
| esel_i | input | 2 | E source: 00 zero, 01 feedback, 10 cascade, 11 zero |
| arsh_i | input | 1 | Arithmetic right shift of E by 17 |
| pasub_i | input | 1 | Pre-adder subtracts D |
| sub_i | input | 1 | Negate product term |
| rom_addr_i | input | 4 | ROM entry select (ROM mode) |
| p_o | output | 48 | Result |
| ovfl_o | output | 1 | Signed overflow of the result sum |
| cdout_o | output | 48 | Cascade copy of p_o |
| b2_o | output | 18 | B delayed by one register |
| bcout_o | output | 18 | Cascade copy of b2_o |

## Verification
The overflow flag and the wraparound of the result land on the same edge. The bench provokes this in both directions: once with C at the largest positive value plus a carry-in, and once with C at the most negative value minus a negated product. It checks the flag and the wrapped result from the same sample. In a second coincidence, the pre-adder subtracts while SUB negates the product, so the two sign flips combine in one sum. The bench checks that combined sum against a model built from the requirements. Feedback accumulation is sampled on consecutive cycles to confirm that exactly one addition happens per edge.

// File: rtl/pa_macc_pkg.sv
package pa_macc_pkg;

  typedef enum logic [1:0] {
    E_ZERO = 2'b00,
    E_FDBK = 2'b01,
    E_CASC = 2'b10,
    E_RSVD = 2'b11
  } esel_e;

  typedef struct packed {
    logic  pasub;
    logic  sub;
    esel_e sel;
    logic  arsh;
    logic  cin;
  } ctrl_t;

  localparam int RomBase = 30000;
  localparam int RomStep = 4096;

  function automatic logic signed [17:0] rom_word(input logic [3:0] k);
    int v;
    v = RomStep * int'(k) - RomBase;
    return 18'(v);
  endfunction

endpackage

// File: rtl/pa_macc_preadd.sv
module pa_macc_preadd
  import pa_macc_pkg::*;
#(
  parameter int DW      = 18,
  parameter int RAW     = 4,
  parameter bit USE_ROM = 1'b0,
  localparam int PRW    = DW + 1,
  localparam int MW     = DW + PRW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] d_i,
  input  logic [RAW-1:0]       addr_i,
  input  logic                 pasub_q_i,
  output logic signed [DW-1:0] b_q_o,
  output logic signed [MW-1:0] prod_o
);

  logic signed [DW-1:0]  b_q, d_q, mop;
  logic signed [PRW-1:0] b_x, d_x, pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '0;
      d_q <= '0;
    end else begin
      b_q <= b_i;
      d_q <= d_i;
    end
  end

  generate
    if (USE_ROM) begin : g_rom
      logic [RAW-1:0] addr_q;
      logic           unused_a;
      assign unused_a = ^a_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) addr_q <= '0;
        else         addr_q <= addr_i;
      end
      assign mop = DW'(rom_word(4'(addr_q)));
    end else begin : g_port
      logic signed [DW-1:0] a_q;
      logic                 unused_addr;
      assign unused_addr = ^addr_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) a_q <= '0;
        else         a_q <= a_i;
      end
      assign mop = a_q;
    end
  endgenerate

  assign b_x = b_q;
  assign d_x = d_q;
  assign pre = pasub_q_i ? (b_x - d_x) : (b_x + d_x);

  always_comb begin
    prod_o = mop * pre;
    b_q_o  = b_q;
  end

  // a zero D must leave B through either pre-adder direction
  always_comb begin
    if (d_q == '0) assert_pre_dzero_R3: assert (pre == b_x);
  end

endmodule

// File: rtl/pa_macc_esel.sv
module pa_macc_esel
  import pa_macc_pkg::*;
#(
  parameter int PW    = 48,
  parameter int SHIFT = 17
) (
  input  esel_e                sel_i,
  input  logic                 arsh_i,
  input  logic signed [PW-1:0] fb_i,
  input  logic signed [PW-1:0] cdin_i,
  output logic signed [PW-1:0] e_o
);

  logic signed [PW-1:0] src;

  always_comb begin
    unique case (sel_i)
      E_FDBK:  src = fb_i;
      E_CASC:  src = cdin_i;
      default: src = '0;
    endcase
    e_o = arsh_i ? (src >>> SHIFT) : src;
  end

  always_comb begin
    if (arsh_i)
      assert_arsh_sign_R6: assert (e_o[PW-1 -: SHIFT+1] == {(SHIFT+1){src[PW-1]}});
    if (sel_i == E_RSVD || sel_i == E_ZERO)
      assert_sel_zero_R5: assert (e_o == '0);
  end

endmodule

// File: rtl/pa_macc_acc.sv
module pa_macc_acc #(
  parameter int PW  = 48,
  parameter int MW  = 37,
  localparam int SW = PW + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [PW-1:0] e_i,
  input  logic signed [PW-1:0] c_i,
  input  logic                 cin_i,
  input  logic                 sub_i,
  input  logic signed [MW-1:0] prod_i,
  output logic signed [PW-1:0] p_o,
  output logic                 ovfl_o
);

  logic signed [SW-1:0] e_x, c_x, m_x, sum;
  logic                 ovf;

  always_comb begin
    e_x = e_i;
    c_x = c_i;
    m_x = prod_i;
    if (sub_i) m_x = -m_x;
    sum = e_x + c_x + m_x + SW'(cin_i);
    // result fits only if bits above PW-1 replicate the sign
    ovf = (sum[SW-1:PW-1] != '0) && (sum[SW-1:PW-1] != '1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o    <= '0;
      ovfl_o <= 1'b0;
    end else begin
      p_o    <= sum[PW-1:0];
      ovfl_o <= ovf;
    end
  end

  assert_zero_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_i == '0 && c_i == '0 && !cin_i && prod_i == '0) |=> (p_o == '0 && !ovfl_o));

endmodule

// File: rtl/pa_macc_slice.sv
module pa_macc_slice
  import pa_macc_pkg::*;
#(
  parameter int DW      = 18,
  parameter int PW      = 48,
  parameter int RAW     = 4,
  parameter int SHIFT   = 17,
  parameter bit USE_ROM = 1'b0,
  localparam int MW     = 2 * DW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] d_i,
  input  logic signed [PW-1:0] c_i,
  input  logic                 cin_i,
  input  logic signed [PW-1:0] cdin_i,
  input  logic [1:0]           esel_i,
  input  logic                 arsh_i,
  input  logic                 pasub_i,
  input  logic                 sub_i,
  input  logic [RAW-1:0]       rom_addr_i,
  output logic signed [PW-1:0] p_o,
  output logic                 ovfl_o,
  output logic signed [PW-1:0] cdout_o,
  output logic signed [DW-1:0] b2_o,
  output logic signed [DW-1:0] bcout_o
);

  ctrl_t                ctrl_q;
  logic signed [PW-1:0] c_q, e_w;
  logic signed [MW-1:0] prod;
  logic                 past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      c_q     <= '0;
      past_ok <= 1'b0;
    end else begin
      ctrl_q  <= '{pasub: pasub_i, sub: sub_i, sel: esel_e'(esel_i),
                   arsh: arsh_i, cin: cin_i};
      c_q     <= c_i;
      past_ok <= 1'b1;
    end
  end

  pa_macc_preadd #(.DW(DW), .RAW(RAW), .USE_ROM(USE_ROM)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (a_i),
    .b_i       (b_i),
    .d_i       (d_i),
    .addr_i    (rom_addr_i),
    .pasub_q_i (ctrl_q.pasub),
    .b_q_o     (b2_o),
    .prod_o    (prod)
  );

  pa_macc_esel #(.PW(PW), .SHIFT(SHIFT)) u_esel (
    .sel_i  (ctrl_q.sel),
    .arsh_i (ctrl_q.arsh),
    .fb_i   (p_o),
    .cdin_i (cdin_i),
    .e_o    (e_w)
  );

  pa_macc_acc #(.PW(PW), .MW(MW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .e_i    (e_w),
    .c_i    (c_q),
    .cin_i  (ctrl_q.cin),
    .sub_i  (ctrl_q.sub),
    .prod_i (prod),
    .p_o    (p_o),
    .ovfl_o (ovfl_o)
  );

  assign cdout_o = p_o;
  assign bcout_o = b2_o;

  assert_b2_pipe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (b2_o == $past(b_i)));

  assert_fb_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.sel == E_FDBK && !ctrl_q.arsh && c_q == '0 && !ctrl_q.cin && prod == '0)
    |=> $stable(p_o));

endmodule

// File: tb/pa_macc_slice_tb_top.sv
`timescale 1ns/1ps
module pa_macc_slice_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic signed [17:0] a, b, d;
  logic signed [47:0] c, cdin;
  logic               cin, arsh, pasub, sub;
  logic [1:0]         sel;
  logic [3:0]         addr;

  logic signed [47:0] p, cdout, p_r, cdout_r;
  logic               ovfl, ovfl_r;
  logic signed [17:0] b2, bcout, b2_r, bcout_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pa_macc_slice #(.USE_ROM(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .d_i(d), .c_i(c), .cin_i(cin),
    .cdin_i(cdin), .esel_i(sel), .arsh_i(arsh), .pasub_i(pasub), .sub_i(sub),
    .rom_addr_i(addr), .p_o(p), .ovfl_o(ovfl), .cdout_o(cdout), .b2_o(b2), .bcout_o(bcout)
  );

  pa_macc_slice #(.USE_ROM(1'b1)) dut_rom_i (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .d_i(d), .c_i(c), .cin_i(cin),
    .cdin_i(cdin), .esel_i(sel), .arsh_i(arsh), .pasub_i(pasub), .sub_i(sub),
    .rom_addr_i(addr), .p_o(p_r), .ovfl_o(ovfl_r), .cdout_o(cdout_r), .b2_o(b2_r),
    .bcout_o(bcout_r)
  );

  localparam longint PMAX = 64'sd140737488355327;
  localparam longint PMIN = -64'sd140737488355328;

  function automatic longint model(longint ma, longint mb, longint md, longint mc,
                                   bit mcin, bit mpasub, bit msub, longint me);
    longint pre, prod;
    pre  = mpasub ? (mb - md) : (mb + md);
    prod = ma * pre;
    if (msub) prod = -prod;
    return me + mc + longint'(mcin) + prod;
  endfunction

  function automatic longint wrap48(longint v);
    logic [47:0] t;
    t = v[47:0];
    return longint'($signed(t));
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_res(string tag, longint exact);
    chk({tag, " p"}, longint'(p), wrap48(exact));
    chk({tag, " ovfl"}, longint'(ovfl), longint'(exact > PMAX || exact < PMIN));
    chk({tag, " cdout==p"}, longint'(cdout), longint'(p));
  endtask

  task automatic drive(longint va, longint vb, longint vd, longint vc, bit vcin,
                       bit vpasub, bit vsub, logic [1:0] vsel, bit varsh, longint vcdin,
                       logic [3:0] vaddr);
    a = 18'(va); b = 18'(vb); d = 18'(vd); c = 48'(vc); cin = vcin;
    pasub = vpasub; sub = vsub; sel = vsel; arsh = varsh; cdin = 48'(vcdin); addr = vaddr;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive(7, 9, 3, 100, 1, 0, 0, 2'b00, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 p", longint'(p), 0);
    chk("R1 ovfl", longint'(ovfl), 0);
    chk("R1 b2", longint'(b2), 0);
    chk("R1 bcout", longint'(bcout), 0);
    chk("R1 cdout", longint'(cdout), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_basic();
    drive(3, 100, 20, 1000, 1, 0, 0, 2'b00, 0, 0, 0);
    settle();
    chk_res("R2 basic", model(3, 100, 20, 1000, 1, 0, 0, 0));
    chk("R10 b2", longint'(b2), 100);
    chk("R10 bcout", longint'(bcout), 100);
  endtask

  task automatic t_presub_negate();
    drive(-5, 10, 30, 7, 0, 1, 1, 2'b00, 0, 0, 0);
    settle();
    chk_res("R3 R4 presub+sub", model(-5, 10, 30, 7, 0, 1, 1, 0));
    drive(-5, 10, 30, 7, 0, 1, 0, 2'b00, 0, 0, 0);
    settle();
    chk_res("R3 presub", model(-5, 10, 30, 7, 0, 1, 0, 0));
  endtask

  task automatic t_cascade();
    drive(2, 3, 4, 1, 0, 0, 0, 2'b10, 0, 64'sd1048576, 0);
    settle();
    chk_res("R5 cascade", model(2, 3, 4, 1, 0, 0, 0, 1048576));
    drive(0, 0, 0, 0, 0, 0, 0, 2'b10, 1, -64'sd393216, 0);
    settle();
    chk_res("R6 shift negative", -3);
    drive(0, 0, 0, 5, 0, 0, 0, 2'b10, 1, 64'sd70368744177664, 0);
    settle();
    chk_res("R6 shift positive", 64'sd536870912 + 5);
    drive(0, 0, 0, 9, 0, 0, 0, 2'b11, 0, 12345, 0);
    settle();
    chk_res("R5 reserved", 9);
  endtask

  task automatic t_feedback();
    drive(0, 0, 0, 1000, 0, 0, 0, 2'b00, 0, 777, 0);
    settle();
    chk_res("R5 zero select", 1000);
    drive(0, 0, 0, 5, 0, 0, 0, 2'b01, 0, 777, 0);
    @(negedge clk);
    @(negedge clk);
    chk_res("R7 acc1", 1005);
    @(negedge clk);
    chk_res("R7 acc2", 1010);
    drive(0, 0, 0, 0, 0, 0, 0, 2'b01, 0, 777, 0);
    settle();
    @(negedge clk);
    chk_res("R7 hold", 1015);
  endtask

  task automatic t_overflow();
    drive(0, 0, 0, PMAX, 1, 0, 0, 2'b00, 0, 0, 0);
    settle();
    chk_res("R9 positive wrap", PMAX + 1);
    drive(1, 1, 0, PMIN, 0, 0, 1, 2'b00, 0, 0, 0);
    settle();
    chk_res("R9 negative wrap", PMIN - 1);
    drive(0, 0, 0, PMAX, 0, 0, 0, 2'b00, 0, 0, 0);
    settle();
    chk_res("R9 edge no overflow", PMAX);
  endtask

  task automatic t_rom();
    drive(999, 2, 0, 0, 0, 0, 0, 2'b00, 0, 0, 4'd15);
    settle();
    chk("R8 rom entry 15", longint'(p_r), 64'sd2 * (4096 * 15 - 30000));
    chk("R8 port mode uses A", longint'(p), 64'sd1998);
    drive(-4, 3, 1, 10, 0, 1, 0, 2'b00, 0, 0, 4'd0);
    settle();
    chk("R8 rom entry 0", longint'(p_r), model(-30000, 3, 1, 10, 0, 1, 0, 0));
    chk("R8 rom b2", longint'(b2_r), 3);
  endtask

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0);
    @(negedge clk);
    t_reset();
    t_basic();
    t_presub_negate();
    t_cascade();
    t_feedback();
    t_overflow();
    t_rom();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule